// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Flag

This block turns an asynchronous serial line into bytes. Each character on the line has a low start bit, eight data bits (least significant first), a ninth bit, and a high stop bit. The line is sampled on an enable tick that runs at a fixed multiple of the bit rate (`OVS` ticks per bit). The receiver finds the falling edge of a start bit and confirms it at the half-bit point. It then samples every later bit at its centre. A finished character goes into a data register and a ready flag is raised. The ready flag falls when the consumer reads the data.

A three-bit mode input sets what the ninth bit means. In the two parity modes the ninth bit is checked against even or odd parity, and a mismatch sets a sticky error flag. In multidrop mode no parity is checked. A ninth bit of one marks the character as an address, and the same sticky flag is raised to report it. Software clears the flag with a one-cycle reset-status pulse.

Top module: `mdrop_uart_rx`

## Requirements
- R1: A character is a low start bit, data bits D0..D7 sent least significant first, a ninth bit, and a stop bit. Each bit lasts `OVS` ticks and is sampled near its centre. The received byte appears on `rxData`.
- R2: With `parMode` = 3'b000 (even), the flag `parErr` is set when the eight data bits plus the ninth bit hold an odd number of ones. With `parMode` = 3'b001 (odd), it is set when they hold an even number of ones.
- R3: Once set, `parErr` stays set until `rstStatus` is high for a cycle. `parErr` is low in the cycle after that pulse, unless R9 applies.
- R4: With `parMode` = 3'b110 or 3'b111 (multidrop), a ninth bit of 1 sets `parErr` to mark an address character. A ninth bit of 0 leaves `parErr` unchanged, whatever the parity of the data.
- R5: With `parMode` = 3'b010, 3'b011, 3'b100 or 3'b101, the ninth bit is not checked and `parErr` is not changed.
- R6: `rxReady` rises in the cycle after the stop bit is sampled high. It falls in the cycle after `dataRead` is high. `rxData` changes only when a new character completes.
- R7: A low level on `rxd` counts as a start bit only if `rxd` is still low at the half-bit point. If it is not, the receiver returns to idle, no byte is delivered, and `rxReady`, `rxData` and `parErr` keep their values.
- R8: If the stop bit is sampled low, the character is dropped. `rxReady`, `rxData` and `parErr` do not change.
- R9: If a character that sets `parErr` completes in the same cycle as a `rstStatus` pulse, `parErr` stays set.
- R10: After reset, `rxReady` = 0, `parErr` = 0 and `rxData` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Enable tick, OVS ticks per bit period |
| rxd | input | 1 | Serial receive line, idles high |
| parMode | input | 3 | 000 even, 001 odd, 11x multidrop, others no check |
| rstStatus | input | 1 | One-cycle pulse that clears the sticky flag |
| dataRead | input | 1 | One-cycle pulse that acknowledges the received byte |
| rxData | output | DW | Last received byte |
| rxReady | output | 1 | Received byte waiting to be read |
| parErr | output | 1 | Sticky parity error or address received |

## Verification
A wrong bit count or a misplaced shift shows up as a bad `rxData` value when the next character completes. That is about eleven bit periods after its start edge. A sampling counter that is off centre, or a start check that is wrong, shows the same way, or as a `rxReady` that never rises or rises for a false start. Mistakes in the flag priority, in the mode decode or in the stop check show in the cycle after the character ends or after the status pulse. The bench therefore places one status pulse exactly on the frame-end cycle.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic shiftBit;   // centre of a data bit: shift it in
    logic takePar;    // centre of the ninth bit: capture it
    logic endFrame;   // centre of the stop bit: commit the frame
  } rxStrobe_t;

  localparam logic [2:0] MODE_EVEN = 3'b000;
  localparam logic [2:0] MODE_ODD  = 3'b001;

endpackage

// File: rtl/mdrx_ctrl.sv
module mdrx_ctrl
  import mdrx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxBit,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DW - 1);

  rxState_e         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             atHalf;
  logic             atFull;

  assign atHalf = sampleTick && (tickCnt == HALF_CNT);
  assign atFull = sampleTick && (tickCnt == FULL_CNT);

  always_comb begin
    stb          = '0;
    stb.shiftBit = (state == ST_DATA) && atFull;
    stb.takePar  = (state == ST_PAR)  && atFull;
    stb.endFrame = (state == ST_STOP) && atFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!rxBit) state <= ST_START;
        end
        ST_START: begin
          if (sampleTick) begin
            if (atHalf) begin
              tickCnt <= '0;
              bitIdx  <= '0;
              state   <= rxBit ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sampleTick) begin
            if (atFull) begin
              tickCnt <= '0;
              bitIdx  <= bitIdx + 1'b1;
              if (bitIdx == LAST_IDX) state <= ST_PAR;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (sampleTick) begin
            if (atFull) begin
              tickCnt <= '0;
              state   <= ST_STOP;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (sampleTick) begin
            if (atFull) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdrx_datapath.sv
module mdrx_datapath
  import mdrx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxd,
  input  rxStrobe_t     stb,
  input  logic [2:0]    parMode,
  input  logic          rstStatus,
  input  logic          dataRead,
  output logic          rxBit,
  output logic [DW-1:0] rxData,
  output logic          rxReady,
  output logic          parErr
);

  logic [1:0]    syncQ;
  logic [DW-1:0] shiftReg;
  logic          parBit;
  logic          dataOnes;
  logic          newErr;
  logic          frameGood;

  // two-stage synchronizer, resets to the idle line level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end
  assign rxBit = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (stb.shiftBit) shiftReg <= {rxBit, shiftReg[DW-1:1]};
      if (stb.takePar)  parBit   <= rxBit;
    end
  end

  assign dataOnes = ^shiftReg;

  always_comb begin
    if (parMode[2:1] == 2'b11)       newErr = parBit;
    else if (parMode == MODE_EVEN)   newErr = parBit ^ dataOnes;
    else if (parMode == MODE_ODD)    newErr = ~(parBit ^ dataOnes);
    else                             newErr = 1'b0;
  end

  assign frameGood = stb.endFrame && rxBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      if (frameGood) begin
        rxData  <= shiftReg;
        rxReady <= 1'b1;
      end else if (dataRead) begin
        rxReady <= 1'b0;
      end
      if (frameGood && newErr) parErr <= 1'b1;
      else if (rstStatus)      parErr <= 1'b0;
    end
  end

endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleTick,
  input  logic          rxd,
  input  logic [2:0]    parMode,
  input  logic          rstStatus,
  input  logic          dataRead,
  output logic [DW-1:0] rxData,
  output logic          rxReady,
  output logic          parErr
);

  rxStrobe_t ctrlStb;
  logic      rxBit;

  mdrx_ctrl #(.OVS(OVS), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxBit      (rxBit),
    .stb        (ctrlStb)
  );

  mdrx_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxd       (rxd),
    .stb       (ctrlStb),
    .parMode   (parMode),
    .rstStatus (rstStatus),
    .dataRead  (dataRead),
    .rxBit     (rxBit),
    .rxData    (rxData),
    .rxReady   (rxReady),
    .parErr    (parErr)
  );

endmodule

// File: rtl/mdrop_uart_rx_chk.sv
module mdrop_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          rstStatus,
  input logic          dataRead,
  input logic          frameEnd,
  input logic [DW-1:0] rxData,
  input logic          rxReady,
  input logic          parErr
);

  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    parErr && !rstStatus |=> parErr);

  p_err_clear_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(parErr) |-> $past(rstStatus));

  p_err_set_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErr) |-> $past(frameEnd));

  p_ready_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxReady) |-> $past(dataRead));

  p_ready_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(frameEnd));

  p_data_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxData) |-> rxReady);

endmodule

bind mdrop_uart_rx mdrop_uart_rx_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rstStatus (rstStatus),
  .dataRead  (dataRead),
  .frameEnd  (ctrlStb.endFrame),
  .rxData    (rxData),
  .rxReady   (rxReady),
  .parErr    (parErr)
);

// File: tb/mdrop_uart_rx_bench.sv
module mdrop_uart_rx_bench;

  localparam int OVS = 16;
  localparam int DW  = 8;
  localparam int FRAME_CYC = 11 * OVS;
  localparam int END_CYC   = 170;  // frame-relative cycle whose edge commits the frame

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleTick = 1'b1;
  logic          rxd = 1'b1;
  logic [2:0]    parMode = 3'b000;
  logic          rstStatus = 1'b0;
  logic          dataRead = 1'b0;
  logic [DW-1:0] rxData;
  logic          rxReady;
  logic          parErr;

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0] expData = '0;
  logic       expReady = 1'b0;
  logic       expErr = 1'b0;

  always #5 clk = ~clk;

  mdrop_uart_rx #(.OVS(OVS), .DW(DW)) u_mdrop_uart_rx (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxd(rxd),
    .parMode(parMode), .rstStatus(rstStatus), .dataRead(dataRead),
    .rxData(rxData), .rxReady(rxReady), .parErr(parErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic errFor(input logic [2:0] m, input logic [7:0] d, input logic ninth);
    if (m == 3'b110 || m == 3'b111) return ninth;
    if (m == 3'b000) return ((^d) ^ ninth);
    if (m == 3'b001) return ~((^d) ^ ninth);
    return 1'b0;
  endfunction

  // rstAt: frame cycle in which rstStatus is high, -1 for none
  task automatic sendFrame(input logic [7:0] d, input logic ninth, input logic stopV, input int rstAt);
    for (int k = 0; k < FRAME_CYC; k++) begin
      @(negedge clk);
      case (k / OVS)
        0:       rxd = 1'b0;
        9:       rxd = ninth;
        10:      rxd = stopV;
        default: rxd = d[k / OVS - 1];
      endcase
      rstStatus = (k == rstAt);
    end
    @(negedge clk);
    rxd = 1'b1;
    rstStatus = 1'b0;
    repeat (24) @(negedge clk);
    if (stopV) begin
      expData  = d;
      expReady = 1'b1;
      if (errFor(parMode, d, ninth)) expErr = 1'b1;
      else if (rstAt == END_CYC) expErr = 1'b0;
    end
  endtask

  task automatic pulseRead();
    @(negedge clk); dataRead = 1'b1;
    @(negedge clk); dataRead = 1'b0;
    expReady = 1'b0;
  endtask

  task automatic pulseRst();
    @(negedge clk); rstStatus = 1'b1;
    @(negedge clk); rstStatus = 1'b0;
    expErr = 1'b0;
  endtask

  task automatic checkAll(input string req);
    chk({req, " data"},  rxData,  expData);
    chk({req, " ready"}, rxReady, expReady);
    chk({req, " flag"},  parErr,  expErr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [2:0] modes [6];
    modes[0] = 3'b000; modes[1] = 3'b001; modes[2] = 3'b110;
    modes[3] = 3'b111; modes[4] = 3'b010; modes[5] = 3'b100;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R10 reset");

    // R1 R2: even parity, correct ninth bit
    parMode = 3'b000;
    sendFrame(8'hA5, 1'b0, 1'b1, -1);
    checkAll("R1 R2 even ok");
    pulseRead();
    @(negedge clk);
    chk("R6 ready falls on read", rxReady, 1'b0);

    // R2: even parity mismatch
    sendFrame(8'h01, 1'b0, 1'b1, -1);
    checkAll("R2 even mismatch");
    // R3: sticky over a clean frame
    sendFrame(8'h3C, 1'b0, 1'b1, -1);
    checkAll("R3 sticky");
    pulseRst();
    @(negedge clk);
    chk("R3 clear", parErr, 1'b0);

    // R2: odd parity
    parMode = 3'b001;
    sendFrame(8'h03, 1'b0, 1'b1, -1);
    checkAll("R2 odd mismatch");
    pulseRst();
    sendFrame(8'h07, 1'b0, 1'b1, -1);
    checkAll("R2 odd ok");

    // R4: multidrop
    parMode = 3'b110;
    sendFrame(8'h01, 1'b0, 1'b1, -1);
    checkAll("R4 data char");
    sendFrame(8'h12, 1'b1, 1'b1, -1);
    checkAll("R4 address char");
    pulseRst();
    parMode = 3'b111;
    sendFrame(8'hF0, 1'b1, 1'b1, -1);
    checkAll("R4 address mode7");
    pulseRst();

    // R5: no-check modes
    parMode = 3'b010;
    sendFrame(8'h01, 1'b0, 1'b1, -1);
    checkAll("R5 mode2");
    parMode = 3'b101;
    sendFrame(8'h80, 1'b1, 1'b1, -1);
    checkAll("R5 mode5");

    // R7: false start
    pulseRead();
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    checkAll("R7 false start");
    parMode = 3'b000;
    sendFrame(8'h5A, 1'b0, 1'b1, -1);
    checkAll("R7 recovers");
    pulseRead();

    // R8: low stop bit drops the frame
    parMode = 3'b110;
    sendFrame(8'hC3, 1'b1, 1'b0, -1);
    checkAll("R8 bad stop");

    // R9: new address wins over same-cycle clear
    sendFrame(8'h21, 1'b1, 1'b1, END_CYC);
    checkAll("R9 set wins");
    // same-cycle clear with no new error clears (R3)
    sendFrame(8'h22, 1'b0, 1'b1, END_CYC);
    checkAll("R3 clear at frame end");

    // random mix
    for (int i = 0; i < 40; i++) begin
      parMode = modes[$urandom % 6];
      sendFrame(8'($urandom), 1'($urandom), 1'b1, -1);
      checkAll("R1 R2 R4 R5 random");
      if (($urandom % 2) == 0) begin
        pulseRead();
        @(negedge clk);
        chk("R6 random read", rxReady, expReady);
      end
      if (($urandom % 3) == 0) begin
        pulseRst();
        @(negedge clk);
        chk("R3 random clear", parErr, expErr);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule